// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block computes X^E mod M. It does not multiply anything itself. It drives a separate Montgomery product engine through a start/done handshake. For each step it chooses the two operands, waits for the product and stores it in its own registers. The engine is assumed to return MM(a,b) = a·b·R^-1 mod M, where R = 2^WIDTH.

The caller supplies:
- the base X;
- the exponent E;
- the two precomputed constants R mod M and R^2 mod M.

The modulus is odd and lies between 2^(WIDTH-1) and 2^WIDTH. The engine is the part that holds it. The caller then pulses `start_i` for one cycle.

The sequencer works in this order:
1. It moves X into the Montgomery domain with a product against R^2 mod M.
2. It seeds its accumulator with R mod M.
3. It skips the leading zero bits of E.
4. For each remaining exponent bit it squares the accumulator, and also multiplies it by the converted base when that bit is 1.
5. It leaves the domain with a final product against 1.

The result is held at `result_o`, and `done_o` pulses once when it is valid.

Top module: `modexp_seq`

## Requirements
- R1: After an accepted start with X < M, `result_o` equals X^E mod M in the cycle where `done_o` is 1.
- R2: For a nonzero E, the first product requested after start has operand a = X and operand b = R^2 mod M.
- R3: For a nonzero E whose highest set bit is at position t-1, exactly 2 + t + popcount(E) products are requested. Leading zero bits of E request none.
- R4: The last product requested before `done_o` has operand b = 1.
- R5: With E = 0, no product is requested. `done_o` is 1 in the cycle after the start cycle, with `result_o` = 1.
- R6: Only one product is outstanding at a time. `mul_start_o` is a one-cycle pulse, and `mul_a_o`/`mul_b_o` stay stable until `mul_done_i` returns.
- R7: A `start_i` pulse while a computation is running is ignored. The running result is unchanged and no extra `done_o` follows.
- R8: `done_o` is high for exactly one cycle. `result_o` keeps its value until the next completion.
- R9: After reset, `done_o` and `mul_start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| x_i | input | WIDTH | Base X, below M |
| exp_i | input | WIDTH | Exponent E |
| rmod_i | input | WIDTH | R mod M |
| rsq_i | input | WIDTH | R^2 mod M |
| mul_start_o | output | 1 | One-cycle request to the product engine |
| mul_a_o | output | WIDTH | First product operand |
| mul_b_o | output | WIDTH | Second product operand |
| mul_done_i | input | 1 | Product-ready pulse from the engine |
| mul_res_i | input | WIDTH | Product MM(a,b) from the engine |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | WIDTH | X^E mod M |

## Verification
The bench builds the block with WIDTH = 32. It attaches a behavioural radix-2 Montgomery engine whose latency cycles through 1, 2 and 3 cycles. At 32 bits, random odd moduli with the top bit set can be compared against a plain 64-bit square-and-multiply reference. Exponents reach every case that matters for the scan: a single set bit at the top position, all ones, small values with long runs of leading zeros, and zero.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    // Sequencer phase; each non-idle phase issues exactly one product
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ENTER,
        PH_SQUARE,
        PH_MULT,
        PH_LEAVE
    } phase_e;

    // Operand source selects
    typedef enum logic [2:0] {
        OPS_ACC,
        OPS_XDOM,
        OPS_ONE,
        OPS_RSQ,
        OPS_XIN
    } opsel_e;

endpackage

// File: rtl/modexp_lead_one.sv
module modexp_lead_one #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Highest set bit; later iterations overwrite earlier ones
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

    always_comb begin
        // R3
        if (any_o) top_bit_set_chk: assert (vec_i[idx_o] == 1'b1);
    end

endmodule

// File: rtl/modexp_operand_mux.sv
module modexp_operand_mux #(
    parameter int WIDTH = 32
) (
    input  modexp_pkg::opsel_e sel_i,
    input  logic [WIDTH-1:0]   acc_i,
    input  logic [WIDTH-1:0]   xdom_i,
    input  logic [WIDTH-1:0]   rsq_i,
    input  logic [WIDTH-1:0]   xin_i,
    output logic [WIDTH-1:0]   val_o
);
    import modexp_pkg::*;

    always_comb begin
        unique case (sel_i)
            OPS_ACC:  val_o = acc_i;
            OPS_XDOM: val_o = xdom_i;
            OPS_ONE:  val_o = WIDTH'(1);
            OPS_RSQ:  val_o = rsq_i;
            OPS_XIN:  val_o = xin_i;
            default:  val_o = acc_i;
        endcase
    end

endmodule

// File: rtl/modexp_seq.sv
module modexp_seq #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] exp_i,
    input  logic [WIDTH-1:0] rmod_i,
    input  logic [WIDTH-1:0] rsq_i,
    output logic             mul_start_o,
    output logic [WIDTH-1:0] mul_a_o,
    output logic [WIDTH-1:0] mul_b_o,
    input  logic             mul_done_i,
    input  logic [WIDTH-1:0] mul_res_i,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    import modexp_pkg::*;

    localparam int IDX_W = $clog2(WIDTH);

    typedef struct packed {
        phase_e           phase;
        logic             waiting;
        logic [WIDTH-1:0] xin;
        logic [WIDTH-1:0] expo;
        logic [WIDTH-1:0] rsq;
        logic [WIDTH-1:0] xdom;
        logic [WIDTH-1:0] acc;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] result;
        logic             done;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;

    logic [IDX_W-1:0] top_idx;
    logic             exp_nonzero;
    opsel_e           sel_d [2];
    logic [WIDTH-1:0] opnd  [2];
    logic             mul_start_d;

    modexp_lead_one #(.WIDTH(WIDTH)) i_lead (
        .vec_i (exp_i),
        .idx_o (top_idx),
        .any_o (exp_nonzero)
    );

    // Operand selects follow the phase only
    always_comb begin
        unique case (cur_q.phase)
            PH_ENTER:  begin sel_d[0] = OPS_XIN; sel_d[1] = OPS_RSQ;  end
            PH_MULT:   begin sel_d[0] = OPS_ACC; sel_d[1] = OPS_XDOM; end
            PH_LEAVE:  begin sel_d[0] = OPS_ACC; sel_d[1] = OPS_ONE;  end
            default:   begin sel_d[0] = OPS_ACC; sel_d[1] = OPS_ACC;  end
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        modexp_operand_mux #(.WIDTH(WIDTH)) i_mux (
            .sel_i  (sel_d[g]),
            .acc_i  (cur_q.acc),
            .xdom_i (cur_q.xdom),
            .rsq_i  (cur_q.rsq),
            .xin_i  (cur_q.xin),
            .val_o  (opnd[g])
        );
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.done  = 1'b0;
        mul_start_d = 1'b0;
        if (cur_q.phase == PH_IDLE) begin
            if (start_i) begin
                nxt_d.xin  = x_i;
                nxt_d.expo = exp_i;
                nxt_d.rsq  = rsq_i;
                nxt_d.acc  = rmod_i;
                nxt_d.idx  = top_idx;
                if (exp_nonzero) begin
                    nxt_d.phase = PH_ENTER;
                end else begin
                    nxt_d.result = WIDTH'(1);
                    nxt_d.done   = 1'b1;
                end
            end
        end else if (!cur_q.waiting) begin
            mul_start_d   = 1'b1;
            nxt_d.waiting = 1'b1;
        end else if (mul_done_i) begin
            nxt_d.waiting = 1'b0;
            unique case (cur_q.phase)
                PH_ENTER: begin
                    nxt_d.xdom  = mul_res_i;
                    nxt_d.phase = PH_SQUARE;
                end
                PH_SQUARE, PH_MULT: begin
                    nxt_d.acc = mul_res_i;
                    if (cur_q.phase == PH_SQUARE && cur_q.expo[cur_q.idx]) begin
                        nxt_d.phase = PH_MULT;
                    end else if (cur_q.idx == '0) begin
                        nxt_d.phase = PH_LEAVE;
                    end else begin
                        nxt_d.idx   = cur_q.idx - 1'b1;
                        nxt_d.phase = PH_SQUARE;
                    end
                end
                PH_LEAVE: begin
                    nxt_d.result = mul_res_i;
                    nxt_d.done   = 1'b1;
                    nxt_d.phase  = PH_IDLE;
                end
                default: nxt_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.phase <= PH_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mul_start_o = mul_start_d;
    assign mul_a_o     = opnd[0];
    assign mul_b_o     = opnd[1];
    assign done_o      = cur_q.done;
    assign result_o    = cur_q.result;

    // R6
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start_o |=> !mul_start_o);

    // R6
    operands_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.waiting && !mul_done_i) |=> ($stable(mul_a_o) && $stable(mul_b_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R7
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase != PH_IDLE) |=> ($stable(cur_q.xin) && $stable(cur_q.expo)));

endmodule

// File: tb/test_modexp_seq.sv
module test_modexp_seq;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  x = '0, e = '0, rmod = '0, rsq = '0;
    logic          mul_start, mul_done = 1'b0, done;
    logic [W-1:0]  mul_a, mul_b, mul_res = '0, result;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] modulus = 32'h8000_0001;

    always #4 clk = ~clk;   // 125 MHz

    modexp_seq #(.WIDTH(W)) i_modexp_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x_i(x), .exp_i(e),
        .rmod_i(rmod), .rsq_i(rsq), .mul_start_o(mul_start), .mul_a_o(mul_a),
        .mul_b_o(mul_b), .mul_done_i(mul_done), .mul_res_i(mul_res),
        .done_o(done), .result_o(result)
    );

    // Bit-serial Montgomery product for the engine model
    function automatic logic [W-1:0] mont(input logic [W-1:0] a, b, m);
        logic [W+1:0] s = '0;
        for (int i = 0; i < W; i++) begin
            if (a[i]) s = s + b;
            if (s[0]) s = s + m;
            s = s >> 1;
        end
        if (s >= {2'b00, m}) s = s - m;
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_pow(input logic [W-1:0] b, ex, m);
        logic [63:0] r = 64'd1 % m;
        logic [63:0] bb = b % m;
        for (int i = 0; i < W; i++) begin
            if (ex[i]) r = (r * bb) % m;
            bb = (bb * bb) % m;
        end
        return r[W-1:0];
    endfunction

    // Product engine model with latency cycling 1..3
    logic         clear_log = 1'b0;
    int           nprod = 0;
    int           lat_cnt = 0;
    logic [W-1:0] cap_a = '0, cap_b = '0, first_a = '0, first_b = '0, last_b = '0;
    always @(posedge clk) begin
        mul_done <= 1'b0;
        if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                mul_done <= 1'b1;
                mul_res  <= mont(cap_a, cap_b, modulus);
            end
        end
        if (clear_log) nprod <= 0;
        if (mul_start) begin
            cap_a   <= mul_a;
            cap_b   <= mul_b;
            last_b  <= mul_b;
            lat_cnt <= 1 + (nprod % 3);
            nprod   <= (clear_log ? 0 : nprod) + 1;
            if (nprod == 0 || clear_log) begin
                first_a <= mul_a;
                first_b <= mul_b;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [W-1:0] act, exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic set_mod(input logic [W-1:0] m);
        logic [63:0] r1;
        modulus = m;
        r1   = (64'd1 << W) % m;
        rmod = r1[W-1:0];
        rsq  = W'((r1 * r1) % m);
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 2000 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic run_case(input logic [W-1:0] xv, ev);
        bit seen;
        int t = 0;
        int pc = 0;
        for (int i = 0; i < W; i++) if (ev[i]) begin t = i + 1; pc++; end
        @(negedge clk);
        x = xv; e = ev; start = 1'b1; clear_log = 1'b1;
        @(negedge clk);
        start = 1'b0; clear_log = 1'b0;
        wait_done(seen);
        chk(seen, "R1 done seen", W'(seen), 1);
        chk(result == ref_pow(xv, ev, modulus), "R1 result", result, ref_pow(xv, ev, modulus));
        chk(first_a == xv && first_b == rsq, "R2 entry operands", first_a, xv);
        chk(nprod == 2 + t + pc, "R3 product count", W'(nprod), W'(2 + t + pc));
        chk(last_b == 1, "R4 exit operand", last_b, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done pulse", W'(done), 0);
        chk(result == ref_pow(xv, ev, modulus), "R8 result held", result, ref_pow(xv, ev, modulus));
    endtask

    task automatic zero_exp_case(input logic [W-1:0] xv);
        @(negedge clk);
        x = xv; e = '0; start = 1'b1; clear_log = 1'b1;
        @(negedge clk);
        start = 1'b0; clear_log = 1'b0;
        chk(done == 1'b1, "R5 done next cycle", W'(done), 1);
        chk(result == 1, "R5 result one", result, 1);
        repeat (3) @(negedge clk);
        chk(nprod == 0, "R5 no products", W'(nprod), 0);
    endtask

    task automatic busy_start_case(input logic [W-1:0] xv, ev, xother);
        bit seen;
        @(negedge clk);
        x = xv; e = ev; start = 1'b1; clear_log = 1'b1;
        @(negedge clk);
        start = 1'b0; clear_log = 1'b0;
        repeat (6) @(negedge clk);
        x = xother; e = 32'h3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen && result == ref_pow(xv, ev, modulus), "R7 busy start ignored",
            result, ref_pow(xv, ev, modulus));
        repeat (300) @(negedge clk);
        chk(done == 1'b0, "R7 no extra done", W'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_mod(32'hF123_4567);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 reset done", W'(done), 0);
        chk(mul_start == 1'b0, "R9 reset mul_start", W'(mul_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(32'h1234_5678, 32'h1);
        run_case(32'h0000_0002, 32'h0000_0005);
        run_case(32'hABCD_0001, 32'hFFFF_FFFF);
        run_case(32'h7777_7777, 32'h8000_0000);
        run_case(32'h0000_0000, 32'h0000_0010);
        zero_exp_case(32'h5555_5555);
        busy_start_case(32'h0BAD_BEEF, 32'h00F0_0F0F, 32'h1111_1111);
        for (int n = 0; n < 12; n++) begin
            logic [W-1:0] m, xv;
            m  = {1'b1, W'($urandom) >> 2, 1'b1} ;
            m  = m | 32'h8000_0001;
            set_mod(m);
            xv = W'($urandom) % m;
            run_case(xv, W'($urandom) >> (n * 2));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule